// File: doc/BRIEF.md
# Compressed audio burst preamble detector

This block sits after a biphase digital audio receiver. It takes the decoded sample words, one 16-bit word per subframe, each marked by a valid strobe. A separate strobe marks every frame boundary. The block looks for the sync pattern that starts a non-linear (compressed) burst. That pattern is a run of zero words, then the word 0xF872, then the word 0x4E1F. The two words that follow the pattern carry the burst information and the burst length code. The block holds both in output registers. It also reports the low five bits of the burst information as the compressed data type, and raises a flag that says a compressed stream is present.

The search looks only at the word values and the valid strobe. The validity flag and the non-audio indication of the stream play no part in it, so a burst is recognised whatever those flags say. A frame counter runs beside the search. If 4096 frames pass without a new burst, the captured values and the flag are cleared.

Top module: `burst_sync_detect`

## Requirements
- R1: A synchronous active-high reset drives burst_info_o, length_o and comp_mode_o to zero, and comp_active_o and sync_o low.
- R2: A burst is recognised only when at least four consecutive valid words equal to 0x0000 come before 0xF872, and 0xF872 is followed by 0x4E1F. The following cases give no capture: fewer zeros, any other non-zero word in place of 0xF872, or any word other than 0x4E1F after 0xF872.
- R3: The first valid word after 0x4E1F is presented on burst_info_o, starting in the cycle after the valid word that follows it has been accepted.
- R4: The second valid word after 0x4E1F is presented on length_o, in the same cycle as R3.
- R5: sync_o is high for exactly one cycle, the cycle after the length word is accepted.
- R6: comp_mode_o equals bits 4:0 of the captured burst information word.
- R7: comp_active_o rises together with sync_o and stays high until the timeout of R9.
- R8: A cycle with word_vld_i low is ignored whatever word_i holds. The matching progress is kept, so zeros split by idle cycles still count as consecutive.
- R9: After 4096 frame strobes with no capture, burst_info_o, length_o and comp_mode_o return to zero and comp_active_o falls. This happens in the cycle after the 4096th strobe.
- R10: A capture restarts the frame count at zero. A frame strobe in the same cycle as the accepted length word is not counted.
- R11: When the word after 0xF872 is not 0x4E1F, the search starts again. If that word is zero, it counts as the first zero of a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 16 | Decoded subframe sample word |
| word_vld_i | input | 1 | word_i holds a new word this cycle |
| frame_i | input | 1 | One-cycle frame boundary strobe |
| burst_info_o | output | 16 | Captured burst information word |
| length_o | output | 16 | Captured burst length code |
| comp_mode_o | output | 5 | Compressed data type (low bits of burst information) |
| comp_active_o | output | 1 | Compressed stream present |
| sync_o | output | 1 | One-cycle pulse on each capture |

## Verification
The assertions check four things on every cycle. A sync pulse lasts one cycle and always comes with the active flag. The flag never rises without a sync pulse. Its fall always leaves the captured fields at zero. A cycle with no valid word and no frame strobe changes nothing. Whether a given word stream should produce a capture cannot be shown by a cycle-local property. The same holds for whether the timeout lands on exactly the 4096th strobe. The bench's scenarios show these by comparing against a model that scans the word history: short zero runs, a broken second sync word, idle gaps inside the run, and a frame strobe that coincides with a capture.

// File: rtl/burst_sync_pkg.sv
package burst_sync_pkg;
  typedef enum logic [1:0] {
    ST_ZEROS  = 2'd0,
    ST_SECOND = 2'd1,
    ST_INFO   = 2'd2,
    ST_LEN    = 2'd3
  } match_st_t;
endpackage

// File: rtl/burst_sync_fsm.sv
module burst_sync_fsm
  import burst_sync_pkg::*;
#(
  parameter int              WORD_W    = 16,
  parameter int              MIN_ZEROS = 4,
  parameter logic [WORD_W-1:0] SYNC_A  = 16'hF872,
  parameter logic [WORD_W-1:0] SYNC_B  = 16'h4E1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              vld_i,
  output logic              cap_o,
  output logic [WORD_W-1:0] info_o
);
  localparam int ZC_W = $clog2(MIN_ZEROS + 1);
  localparam logic [ZC_W-1:0] ZC_MAX = ZC_W'(MIN_ZEROS);

  match_st_t       state;
  logic [ZC_W-1:0] zrun;
  logic            is_zero;

  assign is_zero = (word_i == '0);
  assign cap_o   = vld_i && (state == ST_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_ZEROS;
      zrun   <= '0;
      info_o <= '0;
    end else if (vld_i) begin
      case (state)
        ST_ZEROS: begin
          if (is_zero) begin
            if (zrun != ZC_MAX) zrun <= zrun + 1'b1;
          end else if (word_i == SYNC_A && zrun == ZC_MAX) begin
            state <= ST_SECOND;
            zrun  <= '0;
          end else begin
            zrun <= '0;
          end
        end
        ST_SECOND: begin
          if (word_i == SYNC_B) begin
            state <= ST_INFO;
          end else begin
            state <= ST_ZEROS;
            zrun  <= is_zero ? ZC_W'(1) : '0;
          end
        end
        ST_INFO: begin
          info_o <= word_i;
          state  <= ST_LEN;
        end
        default: begin
          state <= ST_ZEROS;
          zrun  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/burst_frame_timer.sv
module burst_frame_timer #(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int TMR_W = $clog2(TIMEOUT_FRAMES) + 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT_FRAMES - 1);

  logic [TMR_W-1:0] cnt;

  assign expire_o = frame_i && !restart_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt <= '0;
    end else if (frame_i) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/burst_capture_regs.sv
module burst_capture_regs #(
  parameter int WORD_W = 16,
  parameter int MODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] info_i,
  input  logic [WORD_W-1:0] len_i,
  output logic [WORD_W-1:0] info_o,
  output logic [WORD_W-1:0] len_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              active_o,
  output logic              sync_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      info_o   <= '0;
      len_o    <= '0;
      mode_o   <= '0;
      active_o <= 1'b0;
      sync_o   <= 1'b0;
    end else if (cap_i) begin
      info_o   <= info_i;
      len_o    <= len_i;
      mode_o   <= info_i[MODE_W-1:0];
      active_o <= 1'b1;
      sync_o   <= 1'b1;
    end else begin
      sync_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_sync_detect.sv
module burst_sync_detect #(
  parameter int                WORD_W         = 16,
  parameter int                MIN_ZEROS      = 4,
  parameter int                TIMEOUT_FRAMES = 4096,
  parameter int                MODE_W         = 5,
  parameter logic [WORD_W-1:0] SYNC_A         = 16'hF872,
  parameter logic [WORD_W-1:0] SYNC_B         = 16'h4E1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              frame_i,
  output logic [WORD_W-1:0] burst_info_o,
  output logic [WORD_W-1:0] length_o,
  output logic [MODE_W-1:0] comp_mode_o,
  output logic              comp_active_o,
  output logic              sync_o
);
  logic              cap;
  logic              expire;
  logic [WORD_W-1:0] info_held;

  burst_sync_fsm #(
    .WORD_W(WORD_W), .MIN_ZEROS(MIN_ZEROS), .SYNC_A(SYNC_A), .SYNC_B(SYNC_B)
  ) u_fsm (
    .clk(clk), .rst(rst), .word_i(word_i), .vld_i(word_vld_i),
    .cap_o(cap), .info_o(info_held)
  );

  burst_frame_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_tmr (
    .clk(clk), .rst(rst), .frame_i(frame_i), .restart_i(cap), .expire_o(expire)
  );

  burst_capture_regs #(.WORD_W(WORD_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst(rst), .cap_i(cap), .clear_i(expire),
    .info_i(info_held), .len_i(word_i),
    .info_o(burst_info_o), .len_o(length_o), .mode_o(comp_mode_o),
    .active_o(comp_active_o), .sync_o(sync_o)
  );
endmodule

// File: rtl/burst_sync_detect_chk.sv
module burst_sync_detect_chk #(
  parameter int WORD_W = 16,
  parameter int MODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              word_vld_i,
  input logic              frame_i,
  input logic [WORD_W-1:0] burst_info_o,
  input logic [WORD_W-1:0] length_o,
  input logic [MODE_W-1:0] comp_mode_o,
  input logic              comp_active_o,
  input logic              sync_o
);
  // R5
  sync_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> comp_active_o);
  // R5
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);
  // R7
  active_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(comp_active_o) |-> sync_o);
  // R9
  clear_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(comp_active_o) |-> (burst_info_o == '0 && length_o == '0 && comp_mode_o == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_vld_i && !frame_i) |=> ($stable(burst_info_o) && $stable(length_o) && !sync_o));
endmodule

bind burst_sync_detect burst_sync_detect_chk #(.WORD_W(WORD_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/burst_sync_detect_tb.sv
`timescale 1ns/1ps
module burst_sync_detect_tb;
  localparam logic [15:0] SA = 16'hF872;
  localparam logic [15:0] SB = 16'h4E1F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] word_i = '0;
  logic        word_vld_i = 1'b0;
  logic        frame_i = 1'b0;
  logic [15:0] burst_info_o, length_o;
  logic [4:0]  comp_mode_o;
  logic        comp_active_o, sync_o;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  burst_sync_detect u_dut (
    .clk(clk), .rst(rst), .word_i(word_i), .word_vld_i(word_vld_i), .frame_i(frame_i),
    .burst_info_o(burst_info_o), .length_o(length_o), .comp_mode_o(comp_mode_o),
    .comp_active_o(comp_active_o), .sync_o(sync_o)
  );

  // behavioural reference: word history scan
  logic [15:0] hist[$];
  int          base = 0;
  int          fcount = 0;
  logic [15:0] e_info = '0, e_len = '0;
  logic        e_act = 0, e_sync = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist.delete(); base = 0; fcount = 0;
      e_info = '0; e_len = '0; e_act = 0; e_sync = 0;
      model_on = 1;
    end else begin
      bit hit;
      int n;
      hit = 0;
      e_sync = 0;
      if (word_vld_i) begin
        hist.push_back(word_i);
        n = hist.size();
        if (n - base >= 8 && hist[n-8] == 0 && hist[n-7] == 0 && hist[n-6] == 0 &&
            hist[n-5] == 0 && hist[n-4] == SA && hist[n-3] == SB) begin
          e_info = hist[n-2]; e_len = hist[n-1];
          e_act = 1; e_sync = 1; hit = 1; base = n;
        end
      end
      if (hit) fcount = 0;
      else if (frame_i) begin
        fcount++;
        if (fcount == 4096) begin
          fcount = 0; e_info = '0; e_len = '0; e_act = 0;
        end
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      cmp("R3 burst_info_o", burst_info_o, e_info);
      cmp("R4 length_o", length_o, e_len);
      cmp("R6 comp_mode_o", comp_mode_o, e_info[4:0]);
      cmp("R7 comp_active_o", comp_active_o, e_act);
      cmp("R5 sync_o", sync_o, e_sync);
    end
  end

  task automatic put(input logic [15:0] w, input logic v, input logic f);
    @(posedge clk); #1;
    word_i = w; word_vld_i = v; frame_i = f;
  endtask

  task automatic settle();
    put(16'h0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic burst(input int nz, input logic [15:0] c, input logic [15:0] d);
    for (int i = 0; i < nz; i++) put(16'h0, 1'b1, 1'b0);
    put(SA, 1'b1, 1'b0);
    put(SB, 1'b1, 1'b0);
    put(c, 1'b1, 1'b0);
    put(d, 1'b1, 1'b0);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) put(16'h0, 1'b0, 1'b1);
    settle();
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    cmp("R1 reset info", burst_info_o, 0);
    cmp("R1 reset length", length_o, 0);
    cmp("R1 reset active", comp_active_o, 0);
    cmp("R1 reset sync", sync_o, 0);

    // R3 R4 R5 R6 R7: normal burst
    burst(4, 16'h1234, 16'h0800);
    settle();
    cmp("R5 sync pulse", sync_o, 1);
    cmp("R3 info", burst_info_o, 16'h1234);
    cmp("R4 length", length_o, 16'h0800);
    cmp("R6 mode", comp_mode_o, 5'h14);
    settle();
    cmp("R5 sync one cycle", sync_o, 0);

    // R2: three zeros only
    burst(3, 16'hAAAA, 16'h5555);
    settle(); settle();
    cmp("R2 short zero run", burst_info_o, 16'h1234);

    // R2: nonzero in run, then wrong second word
    put(16'h0, 1'b1, 1'b0); put(16'h0, 1'b1, 1'b0); put(16'h0007, 1'b1, 1'b0);
    burst(2, 16'hBBBB, 16'h1111);
    burst(5, 16'h0001, 16'h0002);
    settle();
    cmp("R2 first capture after long run", burst_info_o, 16'h0001);
    for (int i = 0; i < 4; i++) put(16'h0, 1'b1, 1'b0);
    put(SA, 1'b1, 1'b0); put(16'h1234, 1'b1, 1'b0); put(SB, 1'b1, 1'b0);
    put(16'hCCCC, 1'b1, 1'b0); put(16'hDDDD, 1'b1, 1'b0);
    settle(); settle();
    cmp("R2 broken second word", burst_info_o, 16'h0001);

    // R11: zero after failed second word starts new run
    for (int i = 0; i < 4; i++) put(16'h0, 1'b1, 1'b0);
    put(SA, 1'b1, 1'b0); put(16'h0, 1'b1, 1'b0);
    burst(3, 16'h00E3, 16'h0040);
    settle();
    cmp("R11 rerun from zero", burst_info_o, 16'h00E3);

    // R8: idle cycles with garbage inside zero run and preambles
    put(16'h0, 1'b1, 1'b0); put(16'hFFFF, 1'b0, 1'b0); put(16'h0, 1'b1, 1'b0);
    put(SA, 1'b0, 1'b0); put(16'h0, 1'b1, 1'b0); put(16'h9999, 1'b0, 1'b0);
    put(16'h0, 1'b1, 1'b0); put(SA, 1'b1, 1'b0); put(16'h7777, 1'b0, 1'b0);
    put(SB, 1'b1, 1'b0); put(16'h00C8, 1'b1, 1'b0); put(SB, 1'b0, 1'b0);
    put(16'h0123, 1'b1, 1'b0);
    settle();
    cmp("R8 gaps ignored info", burst_info_o, 16'h00C8);
    cmp("R8 gaps ignored length", length_o, 16'h0123);

    // R9: timeout after 4096 frames
    frames(4095);
    cmp("R9 still active at 4095", comp_active_o, 1);
    frames(1);
    cmp("R9 cleared active", comp_active_o, 0);
    cmp("R9 cleared info", burst_info_o, 0);

    // R10: frame in capture cycle not counted; capture restarts count
    for (int i = 0; i < 4; i++) put(16'h0, 1'b1, 1'b0);
    put(SA, 1'b1, 1'b0); put(SB, 1'b1, 1'b0); put(16'h0015, 1'b1, 1'b1);
    put(16'h0100, 1'b1, 1'b1);
    settle();
    cmp("R10 captured", comp_active_o, 1);
    frames(3000);
    burst(4, 16'h0016, 16'h0200);
    frames(4095);
    cmp("R10 restarted count", comp_active_o, 1);
    cmp("R10 info kept", burst_info_o, 16'h0016);
    frames(1);
    cmp("R10 timeout after restart", comp_active_o, 0);

    settle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule